// File: doc/BRIEF.md
# Prioritised Sound Event Interrupt Controller

This block gathers one-cycle request strobes from up to eight numbered event sources in a sound subsystem. It drives a single fast-interrupt line to an embedded processor. Each source has its own sticky pending bit. A small register reports one event number to the processor, chosen by numeric priority rather than by arrival order: a lower number wins.

Software acknowledges events by writing a clear register. The block counts these writes, and only every fourth write takes effect. An effective clear drops the lowest pending event. It then points the reported number at the next pending event above it, and releases the interrupt once nothing is left pending.

Top module: `snd_irq_prio`

## Requirements
- R1: Each of the eight event strobes (`evt_stb[k]` for event k, bit k of `pend_mask`) sets its pending bit on the clock edge where it is high. The bit stays set until an effective clear removes it.
- R2: `irq` is high exactly when at least one pending bit is set. An event arriving with nothing pending raises `irq` on the clock edge that latches it.
- R3: An event updates `evt_id` only if `evt_id` holds 0 or the event's number is lower than the value held. Otherwise `evt_id` keeps its value.
- R4: Writes on `clr_wr` advance a modulo-4 counter that starts at 0. Only the write that returns the counter to 0 (the 4th, 8th, ... write since reset) is an effective clear. The other writes change no output.
- R5: An effective clear removes only the lowest-numbered pending bit.
- R6: After an effective clear, `evt_id` takes the number of the lowest bit still pending. If no bit remains, or nothing was pending, `evt_id` keeps its value.
- R7: When an effective clear leaves no bit pending and no event arrives in that cycle, `irq` falls on that clock edge.
- R8: When an effective clear and event strobes share a cycle, the clear is applied first. The new bits are then set, and the R3 comparison uses the value of `evt_id` that results from the clear.
- R9: Several strobes in one cycle are all latched. Only the lowest of them is compared under R3.
- R10: While `rst_n` is low, all pending bits, the clear counter and `evt_id` are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_stb | input | 8 | One strobe per event source, bit k is event k |
| clr_wr | input | 1 | One-cycle strobe for a write to the clear register |
| irq | output | 1 | Fast-interrupt request to the processor |
| evt_id | output | 3 | Reported event number |
| pend_mask | output | 8 | Pending bit per event |

## Verification
The bench uses the default parameters: eight sources and a clear divisor of four. With a divisor of four, an effective clear comes within a few writes, so directed sequences can reach each of these cases in a handful of cycles:
- a clear that empties the mask;
- a clear with nothing pending;
- a clear that coincides with new strobes.

With eight sources, random traffic often produces several strobes in one cycle, and events that arrive above and below the reported number. A bench model built from the requirements predicts the mask, the number and the interrupt after every cycle.

// File: rtl/snd_irq_pkg.sv
package snd_irq_pkg;
  parameter int unsigned EVT_COUNT_DEF = 8;
  parameter int unsigned CLR_DIV_DEF   = 4;
endpackage

// File: rtl/snd_irq_lowest.sv
module snd_irq_lowest #(
  parameter int unsigned N = 8,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic         hit,
  output logic [W-1:0] idx,
  output logic [N-1:0] oh
);
  // Scan from the top down so the lowest set bit is the last one kept.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    oh  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec[k]) begin
        hit   = 1'b1;
        idx   = W'(k);
        oh    = '0;
        oh[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/snd_irq_clr_pacer.sv
module snd_irq_clr_pacer #(
  parameter int unsigned DIV = 4,
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1,
  localparam logic [CW-1:0] LAST = CW'(DIV - 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_wr,
  output logic fire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_wr;
    fire   = clr_wr && (cnt_q == LAST);
    cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R4: the write that completes a group wraps the counter to zero.
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && cnt_q == LAST) |=> (cnt_q == '0));
  // R4: with no write the counter holds.
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> $stable(cnt_q));
endmodule

// File: rtl/snd_irq_prio.sv
module snd_irq_prio
  import snd_irq_pkg::*;
#(
  parameter int unsigned NUM_EVT = EVT_COUNT_DEF,
  parameter int unsigned CLR_DIV = CLR_DIV_DEF,
  localparam int unsigned IW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_stb,
  input  logic               clr_wr,
  output logic               irq,
  output logic [IW-1:0]      evt_id,
  output logic [NUM_EVT-1:0] pend_mask
);
  logic [NUM_EVT-1:0] pend_q, pend_d, pend_cut;
  logic [IW-1:0]      id_q, id_d, id_mid;
  logic               irq_q, irq_d;
  logic               pend_en, id_en;
  logic               clr_fire;

  logic               p_hit, r_hit, e_hit;
  logic [IW-1:0]      p_idx, r_idx, e_idx;
  logic [NUM_EVT-1:0] p_oh, r_oh, e_oh;

  snd_irq_clr_pacer #(.DIV(CLR_DIV)) u_pacer (
    .clk(clk), .rst_n(rst_n), .clr_wr(clr_wr), .fire(clr_fire));

  // Lowest bit currently pending: the target of an effective clear.
  snd_irq_lowest #(.N(NUM_EVT)) u_pick_pend (
    .vec(pend_q), .hit(p_hit), .idx(p_idx), .oh(p_oh));

  // Lowest bit left after the clear: the next number to report.
  snd_irq_lowest #(.N(NUM_EVT)) u_pick_rest (
    .vec(pend_cut), .hit(r_hit), .idx(r_idx), .oh(r_oh));

  // Lowest of the strobes arriving this cycle.
  snd_irq_lowest #(.N(NUM_EVT)) u_pick_evt (
    .vec(evt_stb), .hit(e_hit), .idx(e_idx), .oh(e_oh));

  always_comb begin
    // Clear stage first.
    pend_cut = clr_fire ? (pend_q & ~p_oh) : pend_q;
    id_mid   = (clr_fire && p_hit && r_hit) ? r_idx : id_q;
    // Event stage on the post-clear state.
    pend_d   = pend_cut | evt_stb;
    if (e_hit && ((id_mid == '0) || (e_idx < id_mid))) id_d = e_idx;
    else                                                 id_d = id_mid;
    irq_d    = |pend_d;
    pend_en  = clr_fire || e_hit;
    id_en    = pend_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     id_q <= '0;
    else if (id_en) id_q <= id_d;
  end

  assign irq       = irq_q;
  assign evt_id    = id_q;
  assign pend_mask = pend_q;

  // R2: the interrupt register agrees with the pending mask.
  assert_irq_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (pend_q != '0));
  // R2: any strobe leaves the line raised.
  assert_irq_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_stb != '0) |=> irq_q);
  // R5: a lone effective clear drops exactly one pending bit.
  assert_clear_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire && pend_q != '0 && evt_stb == '0)
      |=> ($countones(pend_q) + 1 == $countones($past(pend_q))));
  // R1: pending bits never vanish without an effective clear.
  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_fire |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  // R4: idle cycles leave mask and number untouched.
  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_fire && evt_stb == '0) |=> ($stable(pend_q) && $stable(id_q)));
endmodule

// File: tb/snd_irq_prio_tb.sv
`timescale 1ns/1ps
module snd_irq_prio_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] evt_stb;
  logic         clr_wr;
  logic         irq;
  logic [2:0]   evt_id;
  logic [N-1:0] pend_mask;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [N-1:0] m_pend;
  logic [2:0]   m_id;
  int           m_cnt;

  always #2 clk = ~clk;

  snd_irq_prio u_dut (
    .clk(clk), .rst_n(rst_n), .evt_stb(evt_stb), .clr_wr(clr_wr),
    .irq(irq), .evt_id(evt_id), .pend_mask(pend_mask));

  function automatic int lowest_of(input logic [N-1:0] v);
    for (int k = 0; k < N; k++) if (v[k]) return k;
    return -1;
  endfunction

  task automatic model_apply(input logic [N-1:0] e, input bit c);
    if (c) begin
      m_cnt = (m_cnt + 1) % 4;
      if (m_cnt == 0) begin
        int gone;
        gone = lowest_of(m_pend);
        if (gone >= 0) begin
          m_pend[gone] = 1'b0;
          for (int k = gone + 1; k < N; k++)
            if (m_pend[k]) begin m_id = 3'(k); break; end
        end
      end
    end
    begin
      int lo;
      lo = lowest_of(e);
      if (lo >= 0 && (m_id == 0 || lo < int'(m_id))) m_id = 3'(lo);
    end
    m_pend = m_pend | e;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (pend_mask !== m_pend || evt_id !== m_id || irq !== (m_pend != 0)) begin
      errors++;
      $display("FAIL %s: pend=%h id=%0d irq=%b expected pend=%h id=%0d irq=%b",
               tag, pend_mask, evt_id, irq, m_pend, m_id, (m_pend != 0));
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic [N-1:0] e, input bit c, input string tag);
    evt_stb = e;
    clr_wr  = c;
    @(negedge clk);
    model_apply(e, c);
    evt_stb = '0;
    clr_wr  = 1'b0;
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    evt_stb = '0;
    clr_wr = 1'b0;
    m_pend = '0; m_id = '0; m_cnt = 0;
    @(negedge clk);
    compare("R10");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: timeout actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    do_reset();
    // R1 R2: first event raises the line
    step(8'h20, 1'b0, "R1");
    step(8'h80, 1'b0, "R3");       // higher number, id stays 5
    step(8'h08, 1'b0, "R3");       // lower number, id becomes 3
    // R4: three writes do nothing
    step(8'h00, 1'b1, "R4");
    step(8'h00, 1'b1, "R4");
    step(8'h00, 1'b1, "R4");
    step(8'h00, 1'b1, "R5");       // removes 3, id -> 5
    for (int i = 0; i < 3; i++) step(8'h00, 1'b1, "R4");
    step(8'h00, 1'b1, "R6");       // removes 5, id -> 7
    for (int i = 0; i < 3; i++) step(8'h00, 1'b1, "R4");
    step(8'h00, 1'b1, "R7");       // removes 7, empty, id keeps 7, irq low
    for (int i = 0; i < 4; i++) step(8'h00, 1'b1, "R6"); // empty clear
    step(8'h01, 1'b0, "R3");       // 0 < 7 -> id 0
    step(8'h44, 1'b0, "R3");       // id 0 -> takes 2
    for (int i = 0; i < 3; i++) step(8'h00, 1'b1, "R4");
    step(8'h10, 1'b1, "R8");       // clears 0, id->2, then 4 not < 2
    for (int i = 0; i < 3; i++) step(8'h00, 1'b1, "R4");
    step(8'h04, 1'b1, "R8");       // clears 2, id->4, strobe 2 re-sets, id->2
    step(8'hA8, 1'b0, "R9");       // multi strobe, lowest 3 vs id 2
    do_reset();
    step(8'hF0, 1'b0, "R9");       // id 0 -> lowest 4
    do_reset();
    for (int i = 0; i < 600; i++) begin
      logic [N-1:0] e;
      bit c;
      e = ($urandom % 4 == 0) ? N'($urandom) : '0;
      c = ($urandom % 3 == 0);
      step(e, c, "R2");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule